// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. An external address is captured when either of two active-low address strobes is accepted. The top part of that address stays fixed for the rest of the burst. The two low bits pass to a small beat counter, which steps once for every cycle in which the active-low advance input is sampled low.

A static order select input picks how the four beats of a burst are visited. Low gives a linear order that wraps modulo four. High gives an interleaved order, in which the beat number is XORed into the starting low bits. All inputs are sampled on the rising clock edge.

The two strobes have different priorities and qualifications. The processor strobe is honoured only while chip enable 1 is low, and it wins whenever both strobes are low together. A strobe that is honoured while the chip is not fully enabled deselects the block instead of loading an address. The outputs are the registered address and a valid flag.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after reset, `addr_o` is all zeros and `valid_o` is 0.
- R2: A strobe is taken if either the controller strobe is low, or the processor strobe is low while `ce1_ni` is low. When a strobe is taken and the chip is enabled (`ce1_ni`=0, `ce2_i`=1, `ce3_ni`=0), then after the next edge `addr_o` equals the sampled `addr_i` and `valid_o` is 1.
- R3: When both strobes are low with the chip enabled, exactly one capture occurs, and the burst restarts at beat 0 of the sampled address.
- R4: A low processor strobe while `ce1_ni` is high is ignored. With the controller strobe and `advance_ni` both high, `addr_o` and `valid_o` keep their values.
- R5: A strobe that is taken while any chip enable is inactive drives `valid_o` to 0 at the next edge.
- R6: With `order_sel_i`=0, each advance sets the low two bits to start+n modulo 4, where n is the number of advances since the capture.
- R7: With `order_sel_i`=1, each advance sets the low two bits to start XOR n, where n is the number of advances since the capture, modulo 4.
- R8: Bits above bit 1 of `addr_o` do not change during a burst. After four advances the address returns to the captured value.
- R9: A strobe that is taken overrides a low `advance_ni` in the same cycle.
- R10: While `valid_o` is 0 and no strobe is taken, `advance_ni` has no effect: `valid_o` stays 0 and `addr_o` does not change.
- R11: With no strobe taken and `advance_ni` high, `addr_o` and `valid_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| strobe_cpu_ni | input | 1 | Processor address strobe, active low, gated by ce1_ni |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| advance_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Current burst address |
| valid_o | output | 1 | Burst address is valid |

## Verification
The assertions check the following on every cycle:
- a qualified strobe captures the address, and an unqualified one deselects the block;
- a processor strobe made while chip enable 1 is high leaves the state alone;
- the upper bits stay frozen and the linear order steps by one;
- an idle block stays idle under advance.

The interleaved visit order, the return to the start after four beats, and the full set of strobe and enable combinations that follow a partly advanced burst are shown only by the bench's sweeps. The bench compares every cycle against an arithmetic model of the address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  localparam int unsigned BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input order_e            ord
  );
    if (ord == ORD_LINEAR) return start + beat;
    else                   return start ^ beat;
  endfunction
endpackage

// File: rtl/strobe_qualifier.sv
module strobe_qualifier (
  input  logic strobe_cpu_ni,
  input  logic strobe_ctl_ni,
  input  logic ce1_ni,
  input  logic ce2_i,
  input  logic ce3_ni,
  output logic load_o,
  output logic drop_o
);
  logic cpu_take, ctl_take, taken, chip_en;

  // processor strobe is only seen while ce1 is low; it wins over the controller strobe
  assign cpu_take = ~strobe_cpu_ni & ~ce1_ni;
  assign ctl_take = ~strobe_ctl_ni & ~cpu_take;
  assign taken    = cpu_take | ctl_take;
  assign chip_en  = ~ce1_ni & ce2_i & ~ce3_ni;

  assign load_o = taken & chip_en;
  assign drop_o = taken & ~chip_en;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  order_e            order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      base_q  <= addr_i;
      beat_q  <= '0;
      valid_q <= 1'b1;
    end else if (drop_i) begin
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else if (adv_i && valid_q) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign addr_o  = {base_q[ADDR_W-1 -: UPPER_W],
                    beat_offset(base_q[BEAT_W-1:0], beat_q, order_i)};
  assign valid_o = valid_q;

  a_r8_beat_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> beat_q == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_ni,
  input  logic              strobe_ctl_ni,
  input  logic              advance_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic load, drop;
  order_e ord;

  assign ord = order_e'(order_sel_i);

  strobe_qualifier u_qual (
    .strobe_cpu_ni(strobe_cpu_ni),
    .strobe_ctl_ni(strobe_ctl_ni),
    .ce1_ni       (ce1_ni),
    .ce2_i        (ce2_i),
    .ce3_ni       (ce3_ni),
    .load_o       (load),
    .drop_o       (drop)
  );

  burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .drop_i (drop),
    .adv_i  (~advance_ni),
    .addr_i (addr_i),
    .order_i(ord),
    .addr_o (addr_o),
    .valid_o(valid_o)
  );

  logic no_strobe, chip_on;
  assign no_strobe = strobe_ctl_ni & (strobe_cpu_ni | ce1_ni);
  assign chip_on   = ~ce1_ni & ce2_i & ~ce3_ni;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_strobe && chip_on) |=> (valid_o && addr_o == $past(addr_i)));

  a_r4_cpu_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_cpu_ni && ce1_ni && strobe_ctl_ni && advance_ni)
      |=> ($stable(addr_o) && $stable(valid_o)));

  a_r5_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_strobe && !chip_on) |=> !valid_o);

  a_r8_upper_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_strobe && !advance_ni)
      |=> (valid_o && addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  a_r6_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_strobe && !advance_ni && !order_sel_i)
      |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

  a_r10_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && no_strobe) |=> !valid_o);
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int unsigned AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0, ord = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o;

  int errors = 0, checks = 0;
  logic          m_valid = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_n = '0;
  logic          done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .strobe_cpu_ni(cpu_n), .strobe_ctl_ni(ctl_n), .advance_ni(adv_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .order_sel_i(ord),
    .addr_o(addr_o), .valid_o(valid_o)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = ord ? (m_base[1:0] ^ m_n) : (m_base[1:0] + m_n);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    ea = m_valid ? exp_addr() : addr_o;  // address is don't-care while idle except where checked
    checks++;
    if (valid_o !== m_valid || addr_o !== ea) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, valid_o, addr_o, m_valid, ea);
    end
  endtask

  // apply one cycle of inputs, update model, sample after the edge
  task automatic cycle(input logic c, input logic t, input logic e1, input logic e2,
                       input logic e3, input logic a, input logic [AW-1:0] ad,
                       input string tag);
    logic take, en;
    @(negedge clk);
    cpu_n = c; ctl_n = t; ce1_n = e1; ce2 = e2; ce3_n = e3; adv_n = a; addr = ad;
    take = (!c && !e1) || !t;
    en   = !e1 && e2 && !e3;
    if (take && en) begin m_base = ad; m_n = 2'd0; m_valid = 1'b1; end
    else if (take) begin m_valid = 1'b0; m_n = 2'd0; end
    else if (!a && m_valid) m_n = m_n + 2'd1;
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (addr_o !== '0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b addr=%h expected valid=0 addr=0", valid_o, addr_o);
    end
    @(negedge clk); rst_n = 1'b1;

    // R10: advance while idle
    held = addr_o;
    for (int i = 0; i < 3; i++) begin
      cycle(1, 1, 0, 1, 0, 0, '1, "R10");
      checks++;
      if (addr_o !== held) begin
        errors++;
        $display("FAIL R10: addr=%h expected %h", addr_o, held);
      end
    end

    // R6/R7/R8: every start and both orders, six advances each
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); ord = o[0];
        cycle(1, 0, 0, 1, 0, 1, {AW'(17'h1A5C3 + s * 977), 2'(s)} , "R2");
        for (int k = 0; k < 6; k++) begin
          cycle(1, 1, 0, 1, 0, 0, addr, o == 0 ? "R6" : "R7");
          if (k == 3) begin
            checks++;
            if (addr_o !== m_base) begin
              errors++;
              $display("FAIL R8: addr=%h expected %h", addr_o, m_base);
            end
          end
        end
      end
    end

    // R2 processor strobe, R11 hold
    cycle(0, 1, 0, 1, 0, 1, 19'h2F0F1, "R2");
    cycle(1, 1, 0, 1, 0, 0, 19'h00000, "R7");
    cycle(1, 1, 0, 1, 0, 1, 19'h12345, "R11");
    cycle(1, 1, 1, 0, 1, 1, 19'h54321, "R11");

    // sweep all strobe/enable combinations with advance low, from a mid-burst state
    for (int o = 0; o < 2; o++) begin
      for (int v = 0; v < 32; v++) begin
        logic c, t, e1, e2, e3;
        string tg;
        {c, t, e1, e2, e3} = v[4:0];
        @(negedge clk); ord = o[0];
        cycle(1, 0, 0, 1, 0, 1, AW'(v * 4099 + 3), "R2");
        cycle(1, 1, 0, 1, 0, 0, '0, o == 0 ? "R6" : "R7");
        if (!c && !t && !e1 && e2 && !e3)  tg = "R3";
        else if (!c && e1 && t)            tg = "R4";
        else if (((!c && !e1) || !t) && !(!e1 && e2 && !e3)) tg = "R5";
        else if ((!c && !e1) || !t)        tg = "R9";
        else                               tg = "R8";
        cycle(c, t, e1, e2, e3, 0, AW'(v * 7919 + 1), tg);
      end
    end

    // R4 with advance high: state must not move
    cycle(1, 0, 0, 1, 0, 1, 19'h3ABCD, "R2");
    held = addr_o;
    cycle(0, 1, 1, 1, 0, 1, 19'h11111, "R4");
    checks++;
    if (addr_o !== held || valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R4: addr=%h valid=%0b expected %h valid=1", addr_o, valid_o, held);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule